// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

This block is one memory-mapped port of 32 general-purpose pins. Software sets the value each pin drives and whether the pin is driven at all. It reads back the pin levels after they pass through a two-flop synchronizer. Any pin can also be routed into an interrupt detector. The detector watches for a rising edge, a falling edge, a high level or a low level, chosen per pin.

Detected events collect in a sticky pending register. The pending bits are masked by an enable register and ORed into a single interrupt line for the whole port. Every writable register has three write views at fixed offsets inside its 16-byte bank: plain write, write-ones-to-set and write-ones-to-clear. Software can therefore change single bits without a read-modify-write cycle.

The bus is a simple single-cycle interface. Writes commit on the clock edge while the write strobe is high. Read data follows the address combinationally.

Top module: `gpio_irq_port`

## Requirements
- R1: Register banks sit at address bits [6:4]: 0 out-value, 1 pin-input, 2 drive-enable, 3 detect-select, 4 irq-enable, 5 trigger-level, 6 trigger-polarity, 7 pending. A write to view 0 (address bits [3:2] = 0) replaces the register. Writes with address bits [1:0] not zero are ignored.
- R2: A write to view 1 (offset +0x4) ORs the written ones into the register.
- R3: A write to view 2 (offset +0x8) clears the bits written as one. View 3 (offset +0xC) writes are ignored.
- R4: A read at any view of a bank returns the bank's register value.
- R5: The pin-input bank returns the pad levels two clock edges after they change, and writes to any of its views are ignored.
- R6: pad_out always equals the out-value register and pad_oe equals the drive-enable register.
- R7: After reset every register reads zero and irq is low.
- R8: The trigger code per pin is {polarity, level}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. An edge-mode pin sets its pending bit on the third clock edge after the pad changes, and the bit then holds after the pad returns.
- R9: A level-mode pin sets its pending bit on every cycle its level is present. A clear written while the level is still present leaves the bit set.
- R10: A pin whose detect-select bit is 0 never sets its pending bit.
- R11: Pending bits are cleared only through view 2. Writes to view 0 or view 1 of the pending bank are ignored.
- R12: irq is high exactly when some pending bit has its irq-enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address: bank [6:4], view [3:2], must-be-zero [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value to drive on each pad |
| pad_oe | output | 32 | Drive enable for each pad |
| irq | output | 1 | Combined port interrupt |

## Verification
The hardest case to reach from the ports is a clear write landing while a level-mode pin still holds its level. Here the pending bit must survive the clear, yet it must go away once the pad has changed and the pipeline has drained. The stimulus holds a pad high and issues the clear, then reads the bit back. It then drops the pad, waits out the synchronizer and detector latency, and clears again. Edge timing is also checked cycle by cycle: pending is read on the second and then the third edge after a pad change, so an extra or a missing register stage is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        BANK_DOUT = 3'd0,
        BANK_DIN  = 3'd1,
        BANK_DOE  = 3'd2,
        BANK_SEL  = 3'd3,
        BANK_EN   = 3'd4,
        BANK_LVL  = 3'd5,
        BANK_POL  = 3'd6,
        BANK_PEND = 3'd7
    } bank_e;

    typedef enum logic [1:0] {
        ACC_BASE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stg_q [STAGES];
    logic [N-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] sel_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] hit_o
);
    logic [N-1:0] prev_q, prev_d;

    always_comb prev_d = sync_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic lvl_match, edge_match;
        assign lvl_match  = (sync_i[p] == pol_i[p]);
        assign edge_match = pol_i[p] ? (sync_i[p] & ~prev_q[p])
                                     : (~sync_i[p] & prev_q[p]);
        assign hit_o[p] = sel_i[p] & (lvl_i[p] ? lvl_match : edge_match);
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  bank_e        bank,
    input  acc_e         acc,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] din,
    output logic [N-1:0] rdata,
    output logic [N-1:0] dout,
    output logic [N-1:0] doe,
    output logic [N-1:0] sel,
    output logic [N-1:0] en,
    output logic [N-1:0] lvl,
    output logic [N-1:0] pol,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] dout;
        logic [N-1:0] doe;
        logic [N-1:0] sel;
        logic [N-1:0] en;
        logic [N-1:0] lvl;
        logic [N-1:0] pol;
        logic [N-1:0] pend;
    } regs_t;

    regs_t r_q, r_d;

    function automatic logic [N-1:0] apply(input logic [N-1:0] cur,
                                           input acc_e a,
                                           input logic [N-1:0] w);
        case (a)
            ACC_BASE: apply = w;
            ACC_SET:  apply = cur | w;
            ACC_CLR:  apply = cur & ~w;
            default:  apply = cur;
        endcase
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (bank)
                BANK_DOUT: r_d.dout = apply(r_q.dout, acc, wdata);
                BANK_DOE:  r_d.doe  = apply(r_q.doe,  acc, wdata);
                BANK_SEL:  r_d.sel  = apply(r_q.sel,  acc, wdata);
                BANK_EN:   r_d.en   = apply(r_q.en,   acc, wdata);
                BANK_LVL:  r_d.lvl  = apply(r_q.lvl,  acc, wdata);
                BANK_POL:  r_d.pol  = apply(r_q.pol,  acc, wdata);
                BANK_PEND: if (acc == ACC_CLR) r_d.pend = r_q.pend & ~wdata;
                default:   ;
            endcase
        end
        r_d.pend = r_d.pend | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bank)
            BANK_DOUT: rdata = r_q.dout;
            BANK_DIN:  rdata = din;
            BANK_DOE:  rdata = r_q.doe;
            BANK_SEL:  rdata = r_q.sel;
            BANK_EN:   rdata = r_q.en;
            BANK_LVL:  rdata = r_q.lvl;
            BANK_POL:  rdata = r_q.pol;
            default:   rdata = r_q.pend;
        endcase
    end

    assign dout = r_q.dout;
    assign doe  = r_q.doe;
    assign sel  = r_q.sel;
    assign en   = r_q.en;
    assign lvl  = r_q.lvl;
    assign pol  = r_q.pol;
    assign pend = r_q.pend;

    AST_SET_VIEW_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank == BANK_DOUT && acc == ACC_SET)
        |=> ((r_q.dout & $past(wdata)) == $past(wdata))); // R2

    AST_CLR_VIEW_ANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank == BANK_DOE && acc == ACC_CLR)
        |=> ((r_q.doe & $past(wdata)) == '0)); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bank == BANK_PEND && acc == ACC_CLR)
        |=> ((r_q.pend & $past(r_q.pend)) == $past(r_q.pend))); // R11

    AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.pend & $past(hit)) == $past(hit))); // R9

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic              bus_we,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic              irq
);
    localparam int ACC_LSB  = 2;
    localparam int BANK_LSB = 4;

    bank_e        bank;
    acc_e         acc;
    logic         aligned;
    logic [N-1:0] din, hit, dout, doe, sel, en, lvl, pol, pend;

    assign bank    = bank_e'(bus_addr[BANK_LSB +: 3]);
    assign acc     = acc_e'(bus_addr[ACC_LSB +: 2]);
    assign aligned = (bus_addr[ACC_LSB-1:0] == '0);

    gpio_sync #(.N(N), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (din)
    );

    gpio_trig_detect #(.N(N)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (din),
        .sel_i  (sel),
        .lvl_i  (lvl),
        .pol_i  (pol),
        .hit_o  (hit)
    );

    gpio_regfile #(.N(N)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we & aligned),
        .bank  (bank),
        .acc   (acc),
        .wdata (bus_wdata),
        .hit   (hit),
        .din   (din),
        .rdata (bus_rdata),
        .dout  (dout),
        .doe   (doe),
        .sel   (sel),
        .en    (en),
        .lvl   (lvl),
        .pol   (pol),
        .pend  (pend)
    );

    assign pad_out = dout;
    assign pad_oe  = doe;
    assign irq     = |(pend & en);

    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & ~sel) == '0)); // R10

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en != '0 && pend != '0)); // R12

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT_CYCLES = 20000;
    localparam int NVEC = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // {is_write, address, data-or-expected}
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b1, 7'h00, 32'hA5A50000},
        {1'b0, 7'h00, 32'hA5A50000},
        {1'b1, 7'h04, 32'h000000FF},
        {1'b0, 7'h00, 32'hA5A500FF},
        {1'b1, 7'h08, 32'hA000000F},
        {1'b0, 7'h04, 32'h05A500F0},
        {1'b0, 7'h08, 32'h05A500F0},
        {1'b0, 7'h0C, 32'h05A500F0},
        {1'b1, 7'h20, 32'hFFFF0000},
        {1'b1, 7'h24, 32'h0000000F},
        {1'b0, 7'h20, 32'hFFFF000F},
        {1'b1, 7'h28, 32'h00FF0003},
        {1'b0, 7'h28, 32'hFF00000C},
        {1'b1, 7'h10, 32'h12345678},
        {1'b1, 7'h14, 32'hFFFFFFFF},
        {1'b0, 7'h10, 32'h00000000},
        {1'b1, 7'h40, 32'h0000FFFF},
        {1'b1, 7'h48, 32'h0000FF00},
        {1'b0, 7'h40, 32'h000000FF},
        {1'b1, 7'h44, 32'h00000100},
        {1'b0, 7'h4C, 32'h000001FF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * TIMEOUT_CYCLES);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R7: reset state of all banks and irq
        for (int b = 0; b < 8; b++) begin
            rd(7'(b * 16), v);
            chk("R7 reset register", v, 32'h0);
        end
        chk("R7 irq after reset", {31'b0, irq}, 32'h0);

        // Table walk: R1 R2 R3 R4 R5 register views
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][39]) wr(VEC[i][38:32], VEC[i][31:0]);
            else begin
                rd(VEC[i][38:32], v);
                chk("R1 R2 R3 R4 R5 table", v, VEC[i][31:0]);
            end
        end

        // R1: misaligned write ignored
        wr(7'h01, 32'hFFFFFFFF);
        rd(7'h00, v);
        chk("R1 misaligned write", v, 32'h05A500F0);
        // R3: view 3 write ignored
        wr(7'h2C, 32'h00000000);
        rd(7'h20, v);
        chk("R3 view3 ignored", v, 32'hFF00000C);

        // R6: pad drive follows registers
        @(negedge clk);
        chk("R6 pad_out", pad_out, 32'h05A500F0);
        chk("R6 pad_oe", pad_oe, 32'hFF00000C);

        // Interrupt setup
        wr(7'h40, 32'h0);
        wr(7'h50, 32'h0000000C);   // level for pins 2,3
        wr(7'h60, 32'h00000005);   // polarity: pin0 rising, pin2 high
        wr(7'h30, 32'hFFFFFFFF);
        idle(2);

        // R9: low-level pin 3 pending while pad is low
        rd(7'h70, v);
        chk("R9 low level pending", v, 32'h00000008);
        @(negedge clk); pad_in[3] = 1'b1;
        idle(4);
        wr(7'h78, 32'h00000008);
        rd(7'h70, v);
        chk("R3 pend clear after level gone", v, 32'h0);

        // R11: view 0 and view 1 of pending ignored
        wr(7'h70, 32'hFFFFFFFF);
        wr(7'h74, 32'hFFFFFFFF);
        rd(7'h70, v);
        chk("R11 pend base/set ignored", v, 32'h0);

        // R10: pin 31 deselected, pin 30 selected, both see a falling edge
        wr(7'h38, 32'h80000000);
        @(negedge clk); pad_in[31:30] = 2'b11;
        idle(4);
        @(negedge clk); pad_in[31:30] = 2'b00;
        idle(4);
        rd(7'h70, v);
        chk("R10 deselected pin quiet", v, 32'h40000000);
        wr(7'h78, 32'h40000000);

        // R8: rising edge on pin 0, third-edge latency
        @(negedge clk); pad_in[0] = 1'b1;
        rd(7'h70, v);
        chk("R8 rising edge 1", v, 32'h0);
        rd(7'h70, v);
        chk("R8 rising edge 2", v, 32'h0);
        rd(7'h70, v);
        chk("R8 rising edge 3", v, 32'h00000001);
        chk("R12 irq low with enable clear", {31'b0, irq}, 32'h0);
        wr(7'h44, 32'h00000001);
        @(negedge clk);
        chk("R12 irq high when enabled", {31'b0, irq}, 32'h1);
        @(negedge clk); pad_in[0] = 1'b0;
        idle(4);
        rd(7'h70, v);
        chk("R8 edge pending holds", v, 32'h00000001);
        wr(7'h48, 32'h00000001);
        @(negedge clk);
        chk("R12 irq low after disable", {31'b0, irq}, 32'h0);
        wr(7'h78, 32'h00000001);

        // R8: falling edge on pin 1
        @(negedge clk); pad_in[1] = 1'b1;
        idle(4);
        rd(7'h70, v);
        chk("R8 falling ignores rise", v, 32'h0);
        @(negedge clk); pad_in[1] = 1'b0;
        idle(4);
        rd(7'h70, v);
        chk("R8 falling edge sets", v, 32'h00000002);
        wr(7'h78, 32'h00000002);

        // R9: high level on pin 2, clear loses to set
        @(negedge clk); pad_in[2] = 1'b1;
        idle(4);
        wr(7'h78, 32'h00000004);
        rd(7'h70, v);
        chk("R9 set wins over clear", v, 32'h00000004);
        @(negedge clk); pad_in[2] = 1'b0;
        idle(4);
        wr(7'h78, 32'h00000004);
        rd(7'h70, v);
        chk("R9 clear after level drops", v, 32'h0);

        // R5: input read latency
        @(negedge clk); pad_in[23:20] = 4'hF;
        rd(7'h10, v);
        chk("R5 din before sync", v, 32'h00000008);
        rd(7'h10, v);
        chk("R5 din after two edges", v, 32'h00F00008);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule